// File: doc/BRIEF.md
# Keyboard Matrix Scanner

This block walks an 8x8 key switch matrix one crosspoint at a time. A free-running scan position is split into a row index and a column index. The row index drives exactly one of eight row lines high. The column index picks one of eight column return lines through a multiplexer. When the key at the current crosspoint is closed, the block raises a one-cycle key strobe. The code of that key is the scan position itself, and it has been stable on the output since the position was entered.

Each position is held for a fixed dwell of `DWELL` clock cycles. The column lines pass through a multi-flop synchronizer, so the dwell leaves time for a new row drive to reach the synchronized copy before the selected column is evaluated in the last dwell cycle. The position then advances: the column first, and the row when the column wraps. Shift and control modifier inputs go through the same synchronizer and are output next to the key code. A scan-enable input freezes the scan. An active-low synchronous reset restarts it at position zero.

Top module: `kbd_matrix_scan`

## Requirements
- R1: `key_code` is {row index, column index}, with the column index in bits [2:0] and the row index in bits [5:3]. It increases by one after every `DWELL` (default 4) enabled cycles. The column wraps 7 to 0 while the row increments, and the code wraps 63 to 0.
- R2: `row_sel` is always one-hot (active high), and bit k is set exactly when the row index of `key_code` equals k.
- R3: `key_strobe` is high only in the last cycle of a position's dwell. It is high there exactly when `col_in` bit (column index) was high while the current row was driven. Key states at any other crosspoint have no effect on it.
- R4: `key_code` does not change during a position's dwell, so it is valid and stable in every cycle where `key_strobe` is high. The code advances at the clock edge that ends a strobe cycle.
- R5: `mod_shift` and `mod_ctrl` equal `shift_in` and `ctrl_in` as sampled two clock edges earlier.
- R6: While `scan_en` is low, `key_code`, `row_sel` and the dwell position hold, and `key_strobe` is low. Scanning resumes from the same point when `scan_en` returns high.
- R7: A clock edge with `rst_n` low sets `key_code` to 0, `row_sel` to 8'b0000_0001 and the modifier outputs to 0. `key_strobe` stays low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | Scan enable; low freezes the scan and blocks the strobe |
| col_in | input | 8 | Column return lines, high = key at driven row closed |
| shift_in | input | 1 | Shift modifier level |
| ctrl_in | input | 1 | Control modifier level |
| row_sel | output | 8 | One-hot row drive |
| key_code | output | 6 | Current scan position {row, column} |
| key_strobe | output | 1 | Key at current position is pressed (last dwell cycle) |
| mod_shift | output | 1 | Synchronized shift level |
| mod_ctrl | output | 1 | Synchronized control level |

## Verification
The bench models the matrix as 64 key bits routed from `row_sel` to `col_in`. It runs full 64-position sweeps with these key maps: no key, a single key at code 0, a single key at code 63, a single key mid-matrix, a diagonal, a checkerboard, and all keys. Single keys at the ends show whether the row and column fields are placed correctly and whether the wrap works. The diagonal and checkerboard show whether a key in the same row but another column, or in the same column but another row, can leak into the strobe. An all-keys map shows whether the strobe appears at the correct dwell cycle. A pause of the scan while a pressed key sits at the evaluation cycle, and a reset in the middle of a sweep, check the hold and restart behaviour.

// File: rtl/kbd_scan_pkg.sv
// Package: shared constants and types for the keyboard matrix scanner.
// Assumes: a matrix whose row and column counts are powers of two.
package kbd_scan_pkg;

    // Default geometry: 8 rows x 8 columns.
    localparam int unsigned KBD_ROW_BITS = 3;
    localparam int unsigned KBD_COL_BITS = 3;

    // Synchronized modifier pair carried beside the column lines.
    typedef struct packed {
        logic shift;
        logic ctrl;
    } kbd_mod_t;

endpackage

// File: rtl/kbd_scan_counter.sv
// Module: scan position and dwell counter.
// Holds each position for DWELL cycles. eval marks the last dwell cycle,
// and the position advances on the edge that ends it. Because the
// position count is a power of two, the column wraps into the row and
// the code wraps to zero without extra logic.
// Assumes: DWELL >= 2.
module kbd_scan_counter #(
    parameter int unsigned POS_W = 6,
    parameter int unsigned DWELL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    output logic [POS_W-1:0] pos,
    output logic             eval
);
    localparam int unsigned PH_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DWELL - 1);

    logic [PH_W-1:0] phase;

    // Dwell phase and scan position update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            pos   <= '0;
        end else if (adv_en) begin
            if (phase == PH_LAST) begin
                phase <= '0;
                pos   <= pos + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Last dwell cycle indicator.
    assign eval = (phase == PH_LAST);

endmodule

// File: rtl/kbd_sync.sv
// Module: multi-stage synchronizer for a bus of independent levels.
// Each bit is synchronized on its own. There is no coherence between bits.
// Assumes: STAGES >= 1. The reset value is zero.
module kbd_sync #(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture of the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_row_decode.sv
// Module: binary to one-hot row drive decoder.
// Assumes: ROWS == 2**ROW_BITS, so every index selects one row.
module kbd_row_decode #(
    parameter int unsigned ROW_BITS = 3,
    parameter int unsigned ROWS     = 8
) (
    input  logic [ROW_BITS-1:0] row_idx,
    output logic [ROWS-1:0]     row_sel
);
    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            // One comparator per row line.
            assign row_sel[r] = (row_idx == ROW_BITS'(r));
        end
    endgenerate

endmodule

// File: rtl/kbd_matrix_scan.sv
// Module: keyboard matrix scanner top.
// Drives one row at a time and selects one synchronized column line.
// It raises key_strobe in the last dwell cycle when that crosspoint is
// closed. key_code is the raw scan position.
// Assumes: DWELL >= SYNC_STAGES + 1, so that the synchronized column copy
// reflects the current row before evaluation.
module kbd_matrix_scan
    import kbd_scan_pkg::*;
#(
    parameter int unsigned ROW_BITS    = KBD_ROW_BITS,
    parameter int unsigned COL_BITS    = KBD_COL_BITS,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DWELL       = 4,
    localparam int unsigned ROWS   = 1 << ROW_BITS,
    localparam int unsigned COLS   = 1 << COL_BITS,
    localparam int unsigned CODE_W = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic [COLS-1:0]   col_in,
    input  logic              shift_in,
    input  logic              ctrl_in,
    output logic [ROWS-1:0]   row_sel,
    output logic [CODE_W-1:0] key_code,
    output logic              key_strobe,
    output logic              mod_shift,
    output logic              mod_ctrl
);
    localparam int unsigned SYNC_W = COLS + 2;

    logic [CODE_W-1:0]   pos;
    logic                eval;
    logic [SYNC_W-1:0]   sync_out;
    logic [COLS-1:0]     col_s;
    kbd_mod_t            mod_s;
    logic [COL_BITS-1:0] col_idx;
    logic [ROW_BITS-1:0] row_idx;
    logic                col_hit;

    kbd_scan_counter #(
        .POS_W (CODE_W),
        .DWELL (DWELL)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (scan_en),
        .pos    (pos),
        .eval   (eval)
    );

    kbd_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({shift_in, ctrl_in, col_in}),
        .d_out (sync_out)
    );

    // Split the synchronized bus into column lines and modifiers.
    assign col_s = sync_out[COLS-1:0];
    assign mod_s = kbd_mod_t'(sync_out[SYNC_W-1 -: 2]);

    // Row index in the high bits, column index in the low bits.
    assign col_idx = pos[COL_BITS-1:0];
    assign row_idx = pos[CODE_W-1 -: ROW_BITS];

    kbd_row_decode #(
        .ROW_BITS (ROW_BITS),
        .ROWS     (ROWS)
    ) u_row (
        .row_idx (row_idx),
        .row_sel (row_sel)
    );

    // Column multiplexer: sense line of the addressed crosspoint.
    assign col_hit = col_s[col_idx];

    // Strobe only at evaluation while scanning.
    assign key_strobe = scan_en & eval & col_hit;

    assign key_code  = pos;
    assign mod_shift = mod_s.shift;
    assign mod_ctrl  = mod_s.ctrl;

endmodule

// File: rtl/kbd_matrix_scan_chk.sv
// Module: assertion checker for kbd_matrix_scan, attached by bind.
// Assumes: it observes only the ports of the scanner.
module kbd_matrix_scan_chk #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_en,
    input logic              shift_in,
    input logic              ctrl_in,
    input logic [ROWS-1:0]   row_sel,
    input logic [CODE_W-1:0] key_code,
    input logic              key_strobe,
    input logic              mod_shift,
    input logic              mod_ctrl
);
    logic [1:0] since_rst;

    // Count the edges since reset was released, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && key_code != $past(key_code))
            |-> key_code == CODE_W'($past(key_code) + 1'b1)); // R1

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1); // R2

    AST_STROBE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |-> scan_en); // R3

    AST_STROBE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |=> key_code == CODE_W'($past(key_code) + 1'b1)); // R4

    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && key_strobe) |-> $stable(key_code)); // R4

    AST_MOD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |->
            (mod_shift == $past(shift_in, 2) && mod_ctrl == $past(ctrl_in, 2))); // R5

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(key_code)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (key_code == '0 && !key_strobe)); // R7

endmodule

bind kbd_matrix_scan kbd_matrix_scan_chk #(
    .ROWS   (ROWS),
    .CODE_W (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .shift_in   (shift_in),
    .ctrl_in    (ctrl_in),
    .row_sel    (row_sel),
    .key_code   (key_code),
    .key_strobe (key_strobe),
    .mod_shift  (mod_shift),
    .mod_ctrl   (mod_ctrl)
);

// File: tb/kbd_matrix_scan_tb.sv
// Bench: sweeps the whole matrix with several key maps through a modelled
// 8x8 switch array and compares every output in every cycle.
module kbd_matrix_scan_tb;
    localparam int DWELL = 4;
    localparam int NPOS  = 64;
    localparam int SWEEP = DWELL * NPOS;

    logic       clk = 1'b0;
    logic       rst_n, scan_en, shift_in, ctrl_in;
    logic [7:0] col_in, row_sel;
    logic [5:0] key_code;
    logic       key_strobe, mod_shift, mod_ctrl;
    logic [63:0] pressed;

    int  n_chk = 0, n_err = 0, cnt = 0, tick = 0;
    logic sh_d1 = 0, sh_d2 = 0, ct_d1 = 0, ct_d2 = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    kbd_matrix_scan u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .col_in(col_in),
        .shift_in(shift_in), .ctrl_in(ctrl_in), .row_sel(row_sel),
        .key_code(key_code), .key_strobe(key_strobe),
        .mod_shift(mod_shift), .mod_ctrl(mod_ctrl)
    );

    // Switch matrix: a column line is high if any driven row has a closed key.
    always_comb begin
        col_in = '0;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                if (row_sel[r] && pressed[r*8+c]) col_in[c] = 1'b1;
    end

    // Reference: enabled cycle count and modifier delay line.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; sh_d1 <= 0; sh_d2 <= 0; ct_d1 <= 0; ct_d2 <= 0;
        end else begin
            if (scan_en) cnt <= cnt + 1;
            sh_d1 <= shift_in; sh_d2 <= sh_d1;
            ct_d1 <= ctrl_in;  ct_d2 <= ct_d1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: compare all outputs at the falling edge, then drive the modifiers.
    task automatic cyc();
        int pos, ph;
        logic [7:0] exp_row;
        logic exp_str;
        @(negedge clk);
        pos = (cnt / DWELL) % NPOS;
        ph  = cnt % DWELL;
        exp_row = 8'(1 << (pos / 8));
        exp_str = rst_n && scan_en && (ph == DWELL-1) && pressed[pos];
        check(key_code == 6'(pos), "R1 key_code", key_code, pos);
        check(row_sel == exp_row, "R2 row_sel", row_sel, exp_row);
        check(key_strobe == exp_str, "R3 key_strobe", key_strobe, exp_str);
        check(mod_shift == sh_d2 && mod_ctrl == ct_d2, "R5 modifiers",
              {mod_shift, mod_ctrl}, {sh_d2, ct_d2});
        tick++;
        shift_in = tick[3];
        ctrl_in  = tick[2] ^ tick[5];
    endtask

    // Align to the first dwell cycle, load a key map, and run one full sweep.
    task automatic sweep(input logic [63:0] map);
        while (cnt % DWELL != 0) cyc();
        pressed = map;
        repeat (SWEEP) cyc();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        logic [63:0] diag, chk;
        rst_n = 0; scan_en = 0; shift_in = 1; ctrl_in = 1; pressed = '1;
        diag = '0;
        for (int i = 0; i < 8; i++) diag[i*9] = 1'b1;
        for (int i = 0; i < 64; i++) chk[i] = (i[0] ^ i[3]);

        // R7: reset state with every key closed and the modifiers high
        repeat (3) cyc();
        check(key_code == 0 && !key_strobe && row_sel == 8'h01, "R7 reset state",
              {row_sel, key_code}, 8'h01 << 6);
        rst_n = 1; scan_en = 1;

        sweep(64'h0);                    // R3 no key
        sweep(64'h1);                    // R1 R3 code 0
        sweep(64'h1 << 63);              // R1 R3 code 63 wrap
        sweep(64'h1 << 27);              // R3 row 3 col 3
        sweep(diag);                     // R3 same row/column isolation
        sweep(chk);                      // R3 neighbouring crosspoints
        sweep('1);                       // R3 R4 strobe in every position

        // R6: pause with a key pressed at the evaluation cycle
        pressed = '1;
        while (cnt % DWELL != DWELL-1) cyc();
        scan_en = 0;
        repeat (10) begin
            cyc();
            check(!key_strobe, "R6 strobe blocked", key_strobe, 0);
        end
        scan_en = 1;
        repeat (20) cyc();

        // R7: reset in the middle of a sweep
        rst_n = 0;
        repeat (3) cyc();
        check(key_code == 0 && row_sel == 8'h01, "R7 mid-run reset", key_code, 0);
        rst_n = 1;
        sweep(64'h1 << 40);              // R1 restart from zero
        done = 1;
        summary();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

endmodule